// File: doc/BRIEF.md
# Multipulse AC Chopper Gate Generator

This block produces the four gate drives of a single-phase bidirectional AC chopper that uses symmetrical multipulse modulation. Two series switches sit between source and load, one for each current direction. Two shunt switches sit across the load. The block receives the polarity of the source half cycle from a zero-crossing detector. It also receives a sync pulse train whose rate is N times the line frequency, and an unsigned duty word.

A digital sawtooth carrier restarts on every falling edge of the sync train and climbs once per sync period. Comparing the carrier against the duty word gives the chopping pulse. With a sync rate of 2·M times the line frequency, each half cycle holds M pulses of equal spacing.

In each half cycle the series switch for that polarity follows the chopping pulse. Its inverse-parallel partner stays on for the whole half. The shunt pair switches only at line rate and is kept complementary. At every polarity change, all four gates are held off for a programmable dead time before the new pattern begins. All inputs are taken as synchronous to `clk`.

Top module: `smm_gate_gen`

## Requirements
- R1: While `rst` is high, sampled on a rising edge, all four gate outputs are low from the next edge on, and the carrier is cleared.
- R2: The carrier restarts at zero on the clock edge that sees `sync_in` high on the previous edge and low now. It then rises by one every STEP_DIV clocks and saturates at its top value. In a sync period of P clocks (STEP_DIV = 1), the chopped gate is high for min(duty, P) clocks when duty is below the all-ones value.
- R3: A duty word of 0 keeps the chopped series gate low for the whole half cycle.
- R4: The all-ones duty word keeps the chopped series gate high for the whole half cycle, whatever the sync period.
- R5: With `zc_pol` = 1 (positive half), `gate_ser_pos` is chopped and `gate_ser_neg` is held high. With `zc_pol` = 0, `gate_ser_neg` is chopped and `gate_ser_pos` is held high.
- R6: Outside blanking, `gate_shn_pos` equals `zc_pol` and `gate_shn_neg` is its complement. The two shunt gates are never high together.
- R7: After a change of `zc_pol` is sampled on edge E, the outputs of edge E still show the old pattern. Edges E+1 through E+D drive all gates low, and the new pattern starts at edge E+D+1. D is `dead_cfg`, and a value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_pol | input | 1 | Source half-cycle polarity, 1 = positive |
| sync_in | input | 1 | High-rate sync train; the falling edge restarts the carrier |
| duty | input | DUTY_W | Unsigned duty word |
| dead_cfg | input | DEAD_W | Blanking length in clocks (0 treated as 1) |
| gate_ser_pos | output | 1 | Series switch gate, positive current direction |
| gate_ser_neg | output | 1 | Series switch gate, negative current direction |
| gate_shn_pos | output | 1 | Shunt switch gate active in the positive half |
| gate_shn_neg | output | 1 | Shunt switch gate active in the negative half |

## Verification
A polarity change and a carrier restart can land on the same clock edge. In that case the blanking interval and the fresh ramp overlap. The bench provokes this by flipping `zc_pol` at the very negative edge where `sync_in` falls, with duty 100 and a dead time of 5. It then counts over the following 256 clocks. The newly chopped gate must be high for exactly 95 clocks, the new shunt gate for 251, and all gates must be low for exactly 5. This shows that the ramp restarted on time and that blanking masked only the first pulses.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef struct packed {
    logic ser_pos;
    logic ser_neg;
    logic shn_pos;
    logic shn_neg;
  } gate_t;

  localparam gate_t GATES_OFF = '{ser_pos: 1'b0, ser_neg: 1'b0, shn_pos: 1'b0, shn_neg: 1'b0};
endpackage

// File: rtl/smm_carrier.sv
module smm_carrier #(
  parameter int CW       = 8,
  parameter int STEP_DIV = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  output logic [CW-1:0] carrier
);
  localparam logic [CW-1:0] TOP = '1;
  localparam int SW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  logic sync_d;
  logic fall;
  logic adv;

  assign fall = sync_d & ~sync_in;

  generate
    if (STEP_DIV == 1) begin : g_nodiv
      assign adv = 1'b1;
    end else begin : g_div
      logic [SW-1:0] step_q;
      always_ff @(posedge clk) begin
        if (rst || fall) step_q <= '0;
        else if (step_q == SW'(STEP_DIV - 1)) step_q <= '0;
        else step_q <= step_q + 1'b1;
      end
      assign adv = (step_q == SW'(STEP_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d  <= 1'b0;
      carrier <= '0;
    end else begin
      sync_d <= sync_in;
      if (fall) carrier <= '0;
      else if (adv && carrier != TOP) carrier <= carrier + 1'b1;
    end
  end

  // R2: without a restart the ramp never moves down
  p_ramp_mono_r2: assert property (@(posedge clk) disable iff (rst)
    !fall |=> carrier >= $past(carrier));
endmodule

// File: rtl/smm_halfcycle.sv
module smm_halfcycle #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zc_pol,
  input  logic [DEAD_W-1:0] dead_cfg,
  output logic              pol_q,
  output logic              blank
);
  logic [DEAD_W-1:0] blank_cnt;
  logic [DEAD_W-1:0] dead_eff;
  logic              flip;

  assign dead_eff = (dead_cfg == '0) ? DEAD_W'(1) : dead_cfg;
  assign flip     = (zc_pol != pol_q);
  assign blank    = (blank_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q     <= 1'b0;
      blank_cnt <= '0;
    end else if (flip) begin
      pol_q     <= zc_pol;
      blank_cnt <= dead_eff;
    end else if (blank) begin
      blank_cnt <= blank_cnt - 1'b1;
    end
  end

  // R7: every polarity change opens a blanking interval
  p_blank_start_r7: assert property (@(posedge clk) disable iff (rst)
    flip |=> blank);
endmodule

// File: rtl/smm_gate_mux.sv
module smm_gate_mux
  import smm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] carrier,
  input  logic [CW-1:0] duty,
  input  logic          pol_q,
  input  logic          blank,
  output gate_t         gates
);
  logic pulse;

  assign pulse = (duty == '1) | (duty > carrier);

  always_ff @(posedge clk) begin
    if (rst || blank) begin
      gates <= GATES_OFF;
    end else if (pol_q) begin
      gates.ser_pos <= pulse;
      gates.ser_neg <= 1'b1;
      gates.shn_pos <= 1'b1;
      gates.shn_neg <= 1'b0;
    end else begin
      gates.ser_pos <= 1'b1;
      gates.ser_neg <= pulse;
      gates.shn_pos <= 1'b0;
      gates.shn_neg <= 1'b1;
    end
  end

  // R6: shunt pair never conducts together
  p_shunt_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(gates.shn_pos && gates.shn_neg));
  // R7: a blanking cycle yields all gates off
  p_blank_off_r7: assert property (@(posedge clk) disable iff (rst)
    blank |=> (gates == GATES_OFF));
  // R3: zero duty never lets both series switches be on
  p_zero_duty_r3: assert property (@(posedge clk) disable iff (rst)
    (duty == '0 && !blank) |=> !(gates.ser_pos && gates.ser_neg));
  // R4: full duty keeps both series switches on
  p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
    (duty == '1 && !blank) |=> (gates.ser_pos && gates.ser_neg));
  // R5: positive half holds the negative series switch on
  p_partner_on_r5: assert property (@(posedge clk) disable iff (rst)
    (!blank && pol_q) |=> (gates.ser_neg && gates.shn_pos));
endmodule

// File: rtl/smm_gate_gen.sv
module smm_gate_gen
  import smm_pkg::*;
#(
  parameter int DUTY_W   = 8,
  parameter int DEAD_W   = 4,
  parameter int STEP_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zc_pol,
  input  logic              sync_in,
  input  logic [DUTY_W-1:0] duty,
  input  logic [DEAD_W-1:0] dead_cfg,
  output logic              gate_ser_pos,
  output logic              gate_ser_neg,
  output logic              gate_shn_pos,
  output logic              gate_shn_neg
);
  logic [DUTY_W-1:0] carrier;
  logic              pol_q;
  logic              blank;
  gate_t             gates;

  smm_carrier #(.CW(DUTY_W), .STEP_DIV(STEP_DIV)) u_carrier (
    .clk(clk), .rst(rst), .sync_in(sync_in), .carrier(carrier)
  );

  smm_halfcycle #(.DEAD_W(DEAD_W)) u_half (
    .clk(clk), .rst(rst), .zc_pol(zc_pol), .dead_cfg(dead_cfg),
    .pol_q(pol_q), .blank(blank)
  );

  smm_gate_mux #(.CW(DUTY_W)) u_mux (
    .clk(clk), .rst(rst), .carrier(carrier), .duty(duty),
    .pol_q(pol_q), .blank(blank), .gates(gates)
  );

  assign gate_ser_pos = gates.ser_pos;
  assign gate_ser_neg = gates.ser_neg;
  assign gate_shn_pos = gates.shn_pos;
  assign gate_shn_neg = gates.shn_neg;

  // R1: reset leaves every gate off on the following edge
  p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst)
    1'b1 |=> !(gate_ser_pos || gate_ser_neg || gate_shn_pos || gate_shn_neg));
endmodule

// File: tb/smm_gate_gen_test.sv
module smm_gate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zc_pol = 1'b0;
  logic       sync_in = 1'b1;
  logic [7:0] duty = 8'd0;
  logic [3:0] dead_cfg = 4'd3;
  logic       gate_ser_pos, gate_ser_neg, gate_shn_pos, gate_shn_neg;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  int  sync_per = 256;
  int  sync_ph = 0;
  logic pol_next = 1'b0;

  // {polarity, duty, expected high clocks per 256-clock period}
  localparam logic [17:0] VEC [9] = '{
    {1'b1, 8'd128, 9'd128},
    {1'b1, 8'd0,   9'd0},
    {1'b1, 8'd255, 9'd256},
    {1'b0, 8'd64,  9'd64},
    {1'b0, 8'd1,   9'd1},
    {1'b0, 8'd254, 9'd254},
    {1'b1, 8'd200, 9'd200},
    {1'b0, 8'd255, 9'd256},
    {1'b0, 8'd0,   9'd0}
  };

  smm_gate_gen uut (
    .clk(clk), .rst(rst), .zc_pol(zc_pol), .sync_in(sync_in),
    .duty(duty), .dead_cfg(dead_cfg),
    .gate_ser_pos(gate_ser_pos), .gate_ser_neg(gate_ser_neg),
    .gate_shn_pos(gate_shn_pos), .gate_shn_neg(gate_shn_neg)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step1();
    @(negedge clk);
    sync_ph = (sync_ph + 1 >= sync_per) ? 0 : sync_ph + 1;
    sync_in = (sync_ph < sync_per / 2);
    zc_pol  = pol_next;
  endtask

  function automatic bit all_off();
    return !(gate_ser_pos || gate_ser_neg || gate_shn_pos || gate_shn_neg);
  endfunction

  task automatic measure(input int n, output int sp, output int sn,
                         output int hp, output int hn, output int zr);
    sp = 0; sn = 0; hp = 0; hn = 0; zr = 0;
    for (int i = 0; i < n; i++) begin
      step1();
      sp += int'(gate_ser_pos);
      sn += int'(gate_ser_neg);
      hp += int'(gate_shn_pos);
      hn += int'(gate_shn_neg);
      zr += int'(all_off());
    end
  endtask

  task automatic blank_run(input logic [3:0] d);
    int run;
    dead_cfg = d;
    duty = 8'd255;
    for (int i = 0; i < 40; i++) step1();
    pol_next = ~pol_next;
    step1();
    step1();
    run = 0;
    for (int i = 0; i < 40; i++) begin
      step1();
      if (all_off()) run++;
      else break;
    end
    check($sformatf("R7 blank length dead_cfg=%0d", d), run, (d == 0) ? 1 : int'(d));
  endtask

  initial begin
    int sp, sn, hp, hn, zr, act_cnt;
    // R1: reset state
    for (int i = 0; i < 4; i++) step1();
    check("R1 gates during reset", int'(all_off()), 1);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) step1();

    // Table walk: R2 R3 R4 R5 R6
    foreach (VEC[v]) begin
      pol_next = VEC[v][17];
      duty     = VEC[v][16:9];
      for (int i = 0; i < 300; i++) step1();
      measure(256, sp, sn, hp, hn, zr);
      act_cnt = VEC[v][17] ? sp : sn;
      check($sformatf("R2/R3/R4 vec%0d chopped high count", v), act_cnt, int'(VEC[v][8:0]));
      check($sformatf("R5 vec%0d partner held", v), VEC[v][17] ? sn : sp, 256);
      check($sformatf("R6 vec%0d shunt pattern", v),
            VEC[v][17] ? (hp * 1000 + hn) : (hn * 1000 + hp), 256000);
    end

    // R2: short sync period restarts the ramp before it reaches duty
    sync_per = 100;
    pol_next = 1'b1;
    duty = 8'd150;
    for (int i = 0; i < 300; i++) step1();
    measure(100, sp, sn, hp, hn, zr);
    check("R2 restart before compare point", sp, 100);
    duty = 8'd40;
    for (int i = 0; i < 200; i++) step1();
    measure(100, sp, sn, hp, hn, zr);
    check("R2 short period duty 40", sp, 40);
    // R2: long period, ramp saturates
    sync_per = 400;
    duty = 8'd200;
    for (int i = 0; i < 800; i++) step1();
    measure(400, sp, sn, hp, hn, zr);
    check("R2 saturating ramp", sp, 200);
    // R4: full duty over long period
    duty = 8'd255;
    for (int i = 0; i < 400; i++) step1();
    measure(400, sp, sn, hp, hn, zr);
    check("R4 full duty long period", sp, 400);
    sync_per = 256;
    for (int i = 0; i < 300; i++) step1();

    // R7: blanking lengths, including zero treated as one
    blank_run(4'd5);
    blank_run(4'd15);
    blank_run(4'd0);

    // R7 with R2: polarity change on the same edge as a carrier restart
    dead_cfg = 4'd5;
    duty = 8'd100;
    pol_next = 1'b1;
    for (int i = 0; i < 300; i++) step1();
    while (sync_ph != 127) step1();
    pol_next = 1'b0;
    step1();
    step1();
    measure(256, sp, sn, hp, hn, zr);
    check("R7 concurrent: chopped count", sn, 95);
    check("R7 concurrent: new shunt count", hn, 251);
    check("R7 concurrent: all-off count", zr, 5);
    check("R6 concurrent: old shunt off", hp, 0);

    // R1: reset in the middle of operation
    duty = 8'd255;
    for (int i = 0; i < 50; i++) step1();
    rst = 1'b1;
    step1();
    step1();
    check("R1 mid-run reset gates", int'(all_off()), 1);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step1();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule